// File: doc/BRIEF.md
# Parallel Symbol Timing Selector

This block sits behind the inverse transform of a parallel frequency-domain demodulator. Each block of 32 complex time-domain points arrives in one clock, at most once every few clocks (once per 16 converter clocks in the intended system). The block discards the 8 points at each end, which are aliased. It reads the middle 16 as four symbols of four samples each and slices a hard decision from the peak sample of every symbol.

The same block also closes the symbol timing loop. It compares the energy one sample after each peak with the energy one sample before it, then integrates that difference across blocks. When the sum crosses a threshold, it steps a 3-bit index that chooses which matched filter of the frequency-domain bank is applied to later blocks. A lock flag reports that the index has been quiet for a long run of blocks. In BPSK mode only the in-phase decisions carry data.

Top module: `par_sym_timing_sel`

## Requirements
- R1: `sym_valid_o` is high for exactly the one clock that follows a clock with `blk_valid_i` high. The decision outputs change only on that clock edge and hold their value otherwise.
- R2: Points 0..7 and 24..31 of a block, where point p sits at bits [p*SAMP_W +: SAMP_W] of each sample bus, have no effect on any output.
- R3: The decision bit k (k = 0..3) is the sign bit of point 8+4k+2, with 1 meaning negative and 0 meaning zero or positive. It is taken separately for the real bus and the imaginary bus.
- R4: When `bpsk_i` is high with a block, every bit of `dec_im_o` for that block is 0.
- R5: Each block yields a timing error e = sum over k of (|re|+|im|) of point 8+4k+3, minus the same sum over point 8+4k+1. The error is added to a signed accumulator. Without `blk_valid_i`, the accumulator and `filt_sel_o` do not change.
- R6: If accumulator+e >= STEP_THR, `filt_sel_o` increments modulo 8 and the accumulator clears. If accumulator+e <= -STEP_THR, `filt_sel_o` decrements modulo 8 and the accumulator clears. Otherwise the accumulator takes the sum. The index never moves by more than one per block.
- R7: `lock_o` rises after LOCK_BLKS (64) consecutive blocks that produce no index step. It falls on the same edge that steps the index.
- R8: After reset, `filt_sel_o` is 0, `lock_o` is 0, `sym_valid_o` is 0, the decision outputs are 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | A block of 32 points is present this clock |
| bpsk_i | input | 1 | BPSK mode for this block |
| samp_re_i | input | 32*SAMP_W | Real parts, point p at [p*SAMP_W +: SAMP_W], two's complement |
| samp_im_i | input | 32*SAMP_W | Imaginary parts, same layout |
| sym_valid_o | output | 1 | Decisions of the last block are valid |
| dec_re_o | output | 4 | In-phase hard decisions, symbol k at bit k |
| dec_im_o | output | 4 | Quadrature hard decisions, symbol k at bit k |
| filt_sel_o | output | 3 | Matched filter select index |
| lock_o | output | 1 | Timing loop locked |

## Verification
Two things can land on the same edge: a threshold crossing that steps the index, and the lock counter reaching its count. The bench provokes this with 63 error-free blocks followed by a block whose error equals the threshold exactly. It expects the step to win, so lock stays low and the quiet-block count restarts. The bench also runs exact threshold and threshold-minus-one errors, wraps the index in both directions, and sweeps a long run of pseudo-random blocks in both modes. Every block is compared against an arithmetic model of the requirements.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int IN_PTS    = 32;
  localparam int KEEP_PTS  = 16;
  localparam int SPS       = 4;
  localparam int NSYM      = KEEP_PTS / SPS;
  localparam int FIRST_PT  = (IN_PTS - KEEP_PTS) / 2;
  localparam int EARLY_OFS = 1;
  localparam int PEAK_OFS  = 2;
  localparam int LATE_OFS  = 3;
  localparam int SEL_W     = 3;
endpackage

// File: rtl/tsel_pick.sv
module tsel_pick import tsel_pkg::*; #(
  parameter int SAMP_W = 8
) (
  input  logic [IN_PTS*SAMP_W-1:0] re_i,
  input  logic [IN_PTS*SAMP_W-1:0] im_i,
  output logic [NSYM-1:0]          dec_re_o,
  output logic [NSYM-1:0]          dec_im_o,
  output logic [NSYM*SAMP_W-1:0]   early_re_o,
  output logic [NSYM*SAMP_W-1:0]   early_im_o,
  output logic [NSYM*SAMP_W-1:0]   late_re_o,
  output logic [NSYM*SAMP_W-1:0]   late_im_o
);
  // outer (aliased) points and offset-0 taps are intentionally dropped
  logic unused_in;
  assign unused_in = ^{re_i, im_i};

  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    localparam int BASE = FIRST_PT + k * SPS;
    assign dec_re_o[k] = re_i[(BASE + PEAK_OFS) * SAMP_W + SAMP_W - 1];
    assign dec_im_o[k] = im_i[(BASE + PEAK_OFS) * SAMP_W + SAMP_W - 1];
    assign early_re_o[k*SAMP_W +: SAMP_W] = re_i[(BASE + EARLY_OFS) * SAMP_W +: SAMP_W];
    assign early_im_o[k*SAMP_W +: SAMP_W] = im_i[(BASE + EARLY_OFS) * SAMP_W +: SAMP_W];
    assign late_re_o[k*SAMP_W +: SAMP_W]  = re_i[(BASE + LATE_OFS) * SAMP_W +: SAMP_W];
    assign late_im_o[k*SAMP_W +: SAMP_W]  = im_i[(BASE + LATE_OFS) * SAMP_W +: SAMP_W];
  end
endmodule

// File: rtl/tsel_err.sv
module tsel_err import tsel_pkg::*; #(
  parameter int SAMP_W = 8,
  parameter int ERR_W  = SAMP_W + 4
) (
  input  logic [NSYM*SAMP_W-1:0]  early_re_i,
  input  logic [NSYM*SAMP_W-1:0]  early_im_i,
  input  logic [NSYM*SAMP_W-1:0]  late_re_i,
  input  logic [NSYM*SAMP_W-1:0]  late_im_i,
  output logic signed [ERR_W-1:0] err_o
);
  localparam int MAG_W = SAMP_W + 1;
  localparam int SUM_W = ERR_W - 1;

  function automatic logic [MAG_W-1:0] abs_of(input logic [SAMP_W-1:0] a);
    logic signed [MAG_W-1:0] s;
    s = {a[SAMP_W-1], a};
    return s[MAG_W-1] ? MAG_W'(-s) : MAG_W'(s);
  endfunction

  logic [SUM_W-1:0] e_sum, l_sum;

  always_comb begin
    e_sum = '0;
    l_sum = '0;
    for (int k = 0; k < NSYM; k++) begin
      e_sum = e_sum + SUM_W'(abs_of(early_re_i[k*SAMP_W +: SAMP_W]))
                    + SUM_W'(abs_of(early_im_i[k*SAMP_W +: SAMP_W]));
      l_sum = l_sum + SUM_W'(abs_of(late_re_i[k*SAMP_W +: SAMP_W]))
                    + SUM_W'(abs_of(late_im_i[k*SAMP_W +: SAMP_W]));
    end
    err_o = $signed({1'b0, l_sum}) - $signed({1'b0, e_sum});
  end
endmodule

// File: rtl/tsel_loop.sv
module tsel_loop import tsel_pkg::*; #(
  parameter int ERR_W     = 12,
  parameter int ACC_W     = 16,
  parameter int STEP_THR  = 256,
  parameter int LOCK_BLKS = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    blk_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [SEL_W-1:0]        sel_o,
  output logic                    lock_o
);
  localparam int CNT_W = $clog2(LOCK_BLKS + 1);
  localparam logic signed [ACC_W-1:0] THR_P = ACC_W'(STEP_THR);
  localparam logic signed [ACC_W-1:0] THR_N = -THR_P;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_BLKS);

  logic signed [ACC_W-1:0] acc_q, acc_sum;
  logic [SEL_W-1:0]        sel_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    go_up, go_dn;

  always_comb begin
    acc_sum = acc_q + {{(ACC_W-ERR_W){err_i[ERR_W-1]}}, err_i};
    go_up   = acc_sum >= THR_P;
    go_dn   = acc_sum <= THR_N;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sel_q <= '0;
      cnt_q <= '0;
    end else if (blk_i) begin
      if (go_up || go_dn) begin
        acc_q <= '0;
        sel_q <= go_up ? sel_q + 1'b1 : sel_q - 1'b1;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_sum;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sel_o  = sel_q;
  assign lock_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/par_sym_timing_sel.sv
module par_sym_timing_sel import tsel_pkg::*; #(
  parameter int SAMP_W    = 8,
  parameter int ACC_W     = 16,
  parameter int STEP_THR  = 256,
  parameter int LOCK_BLKS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     blk_valid_i,
  input  logic                     bpsk_i,
  input  logic [IN_PTS*SAMP_W-1:0] samp_re_i,
  input  logic [IN_PTS*SAMP_W-1:0] samp_im_i,
  output logic                     sym_valid_o,
  output logic [NSYM-1:0]          dec_re_o,
  output logic [NSYM-1:0]          dec_im_o,
  output logic [SEL_W-1:0]         filt_sel_o,
  output logic                     lock_o
);
  localparam int ERR_W = SAMP_W + 4;

  logic [NSYM-1:0]        pk_re, pk_im;
  logic [NSYM*SAMP_W-1:0] e_re, e_im, l_re, l_im;
  logic signed [ERR_W-1:0] err;
  logic                   vld_q;
  logic [NSYM-1:0]        dre_q, dim_q;

  tsel_pick #(.SAMP_W(SAMP_W)) pick_i (
    .re_i(samp_re_i), .im_i(samp_im_i),
    .dec_re_o(pk_re), .dec_im_o(pk_im),
    .early_re_o(e_re), .early_im_o(e_im),
    .late_re_o(l_re), .late_im_o(l_im)
  );

  tsel_err #(.SAMP_W(SAMP_W), .ERR_W(ERR_W)) err_i (
    .early_re_i(e_re), .early_im_i(e_im),
    .late_re_i(l_re), .late_im_i(l_im),
    .err_o(err)
  );

  tsel_loop #(
    .ERR_W(ERR_W), .ACC_W(ACC_W), .STEP_THR(STEP_THR), .LOCK_BLKS(LOCK_BLKS)
  ) loop_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .blk_i(blk_valid_i), .err_i(err),
    .sel_o(filt_sel_o), .lock_o(lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dre_q <= '0;
      dim_q <= '0;
    end else begin
      vld_q <= blk_valid_i;
      if (blk_valid_i) begin
        dre_q <= pk_re;
        dim_q <= bpsk_i ? '0 : pk_im;
      end
    end
  end

  assign sym_valid_o = vld_q;
  assign dec_re_o    = dre_q;
  assign dec_im_o    = dim_q;
endmodule

// File: rtl/par_sym_timing_sel_chk.sv
module par_sym_timing_sel_chk import tsel_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blk_valid_i,
  input logic             bpsk_i,
  input logic             sym_valid_o,
  input logic [NSYM-1:0]  dec_re_o,
  input logic [NSYM-1:0]  dec_im_o,
  input logic [SEL_W-1:0] filt_sel_o,
  input logic             lock_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_i |=> sym_valid_o); // R1
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_valid_i |=> (!sym_valid_o && $stable(dec_re_o) && $stable(dec_im_o))); // R1
  AST_BPSK_IM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && bpsk_i) |=> (dec_im_o == '0)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_valid_i |=> $stable(filt_sel_o)); // R5
  AST_SEL_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_sel_o) |-> ((filt_sel_o == SEL_W'($past(filt_sel_o) + 1'b1)) ||
                              (filt_sel_o == SEL_W'($past(filt_sel_o) - 1'b1)))); // R6
  AST_STEP_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_sel_o) |-> !lock_o); // R7
  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($stable(filt_sel_o) && $past(blk_valid_i))); // R7
endmodule

bind par_sym_timing_sel par_sym_timing_sel_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .blk_valid_i(blk_valid_i), .bpsk_i(bpsk_i),
  .sym_valid_o(sym_valid_o), .dec_re_o(dec_re_o), .dec_im_o(dec_im_o),
  .filt_sel_o(filt_sel_o), .lock_o(lock_o)
);

// File: tb/par_sym_timing_sel_tb_top.sv
module par_sym_timing_sel_tb_top;
  localparam int W = 8;
  localparam int THR = 256;
  localparam int LOCKN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic bpsk = 1'b0;
  logic [32*W-1:0] re_bus, im_bus;
  logic signed [W-1:0] ai [32];
  logic signed [W-1:0] aq [32];
  logic sv;
  logic [3:0] dre, dim;
  logic [2:0] sel;
  logic lock;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      re_bus[i*W +: W] = ai[i];
      im_bus[i*W +: W] = aq[i];
    end
  end

  par_sym_timing_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(vld), .bpsk_i(bpsk),
    .samp_re_i(re_bus), .samp_im_i(im_bus),
    .sym_valid_o(sv), .dec_re_o(dre), .dec_im_o(dim),
    .filt_sel_o(sel), .lock_o(lock)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int m_acc, m_sel, m_cnt;
  logic [3:0] m_dre, m_dim;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int mag(input int a, input int b);
    return (a < 0 ? -a : a) + (b < 0 ? -b : b);
  endfunction

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic clear_pts();
    for (int i = 0; i < 32; i++) begin ai[i] = '0; aq[i] = '0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0;
    m_acc = 0; m_sel = 0; m_cnt = 0; m_dre = '0; m_dim = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive current ai/aq as one block, update model, check outputs
  task automatic blk(input bit mode, input string tag);
    int e;
    e = 0;
    for (int k = 0; k < 4; k++) begin
      e += mag(ai[8+4*k+3], aq[8+4*k+3]) - mag(ai[8+4*k+1], aq[8+4*k+1]);
      m_dre[k] = ai[8+4*k+2] < 0;
      m_dim[k] = mode ? 1'b0 : (aq[8+4*k+2] < 0);
    end
    m_acc += e;
    if (m_acc >= THR) begin
      m_sel = (m_sel + 1) % 8; m_acc = 0; m_cnt = 0;
    end else if (m_acc <= -THR) begin
      m_sel = (m_sel + 7) % 8; m_acc = 0; m_cnt = 0;
    end else if (m_cnt < LOCKN) m_cnt++;
    bpsk = mode; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(sv == 1'b1, {tag, " R1 valid"}, sv, 1);
    chk(dre == m_dre && dim == m_dim, {tag, " R3 decisions"}, {dre, dim}, {m_dre, m_dim});
    chk(int'(sel) == m_sel, {tag, " R6 sel"}, sel, m_sel);
    chk(lock == (m_cnt == LOCKN), {tag, " R7 lock"}, lock, m_cnt == LOCKN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_pts();
    do_reset();
    @(negedge clk);
    // R8 reset state
    chk(sv == 0 && dre == 0 && dim == 0, "R8 outputs", {sv, dre, dim}, 0);
    chk(sel == 0 && lock == 0, "R8 sel/lock", {sel, lock}, 0);

    // R1: idle clocks keep everything stable
    for (int i = 0; i < 32; i++) begin ai[i] = 8'sd100; aq[i] = -8'sd90; end
    repeat (5) @(negedge clk);
    chk(sv == 0 && sel == 0 && dre == 0, "R1 idle", {sv, sel, dre}, 0);

    // R3/R4/R5/R6 random sweep, both modes
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 32; i++) begin ai[i] = rnd8(); aq[i] = rnd8(); end
      blk(n[0], "rand");
      if (n % 7 == 0) begin
        // R5: no valid -> no change, inputs disturbed meanwhile
        for (int i = 0; i < 32; i++) begin ai[i] = rnd8(); aq[i] = rnd8(); end
        repeat (3) @(negedge clk);
        chk(sv == 0 && int'(sel) == m_sel && dre == m_dre && dim == m_dim,
            "R5 hold", sel, m_sel);
      end
    end

    // R4 explicit: negative imaginary peaks in BPSK mode give zero
    clear_pts();
    for (int k = 0; k < 4; k++) begin ai[8+4*k+2] = -8'sd5; aq[8+4*k+2] = -8'sd7; end
    blk(1'b1, "R4 bpsk");
    chk(dim == 4'h0 && dre == 4'hf, "R4 im zero", {dre, dim}, 8'hf0);
    blk(1'b0, "R3 qpsk");
    chk(dim == 4'hf, "R3 im sign", dim, 15);

    // R2: outer points huge, middle quiet
    do_reset();
    clear_pts();
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 8; i++) begin
        ai[i] = -8'sd128; aq[i] = 8'sd127; ai[24+i] = 8'sd127; aq[24+i] = -8'sd128;
      end
      blk(1'b0, "R2 outer");
    end
    chk(sel == 0 && dre == 0 && dim == 0, "R2 outer ignored", {sel, dre, dim}, 0);

    // R6 exact boundary: 255 no step, +1 steps
    do_reset();
    clear_pts();
    ai[8+3] = 8'sd127; ai[12+3] = 8'sd127; ai[16+3] = 8'sd1;
    blk(1'b0, "R6 thr-1");
    chk(sel == 0, "R6 below thr", sel, 0);
    clear_pts(); ai[8+3] = 8'sd1;
    blk(1'b0, "R6 thr");
    chk(sel == 1, "R6 at thr", sel, 1);

    // R6 wrap upward then downward
    clear_pts();
    for (int k = 0; k < 4; k++) begin ai[8+4*k+3] = 8'sd127; aq[8+4*k+3] = 8'sd127; end
    for (int n = 0; n < 8; n++) blk(1'b0, "R6 up");
    chk(sel == 1, "R6 wrap up", sel, 1);
    clear_pts();
    for (int k = 0; k < 4; k++) begin ai[8+4*k+1] = -8'sd128; aq[8+4*k+1] = 8'sd127; end
    for (int n = 0; n < 3; n++) blk(1'b0, "R6 dn");
    chk(sel == 6, "R6 wrap down", sel, 6);

    // R7: lock after 64 quiet blocks
    do_reset();
    clear_pts();
    for (int n = 0; n < 63; n++) blk(1'b0, "R7 quiet");
    chk(lock == 0, "R7 63 blocks", lock, 0);
    blk(1'b0, "R7 quiet64");
    chk(lock == 1, "R7 64 blocks", lock, 1);
    ai[8+3] = 8'sd127; ai[12+3] = 8'sd127; ai[16+3] = 8'sd2;
    blk(1'b0, "R7 step");
    chk(lock == 0 && sel == 1, "R7 lock drop", {sel, lock}, 2);

    // collision: 64th quiet-count block is also a step
    do_reset();
    clear_pts();
    for (int n = 0; n < 63; n++) blk(1'b0, "R7 pre");
    ai[8+3] = 8'sd127; ai[12+3] = 8'sd127; ai[16+3] = 8'sd2;
    blk(1'b0, "R7 collide");
    chk(lock == 0 && sel == 1, "R7 step beats lock", {sel, lock}, 2);
    clear_pts();
    blk(1'b0, "R7 restart");
    chk(lock == 0, "R7 count restarted", lock, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule